// File: doc/BRIEF.md
# Wrap/Fill 32-bit Shift Array

This block is a purely combinational 32-bit shifter with no clock and no state. It is at heart a left shifter: a 5-bit shift code of n moves the data word n places toward the most significant end. A mode select picks between two conventions. In wrap mode the word is rotated, so bits that leave the top come back in at the bottom. In fill mode, positions with no source bit are filled instead, and the direction bit becomes the sign of a 6-bit two's-complement shift amount formed as {direction, code}.

With the direction bit low, fill mode gives a logical left shift of 0 to 31 places with zeros entering at the bottom. With the direction bit high, the amount is negative: the word moves right by 32 minus the code, and the sign-fill input enters at the top. So a code of all ones gives a right shift of one, and a code of zero gives a right shift of 32, which leaves every output bit equal to the sign-fill input. Seen another way, the block selects any contiguous 32-bit window from a 96-bit word made of 32 copies of the sign-fill bit, then the data, then 32 zeros. Registering, narrowing the output and choosing where the shift code comes from are left to the surrounding logic.

Top module: `shift_wrap_fill`

## Requirements
- R1: With shift code 0, in wrap mode (wrap_en=1) or in fill mode shifting left (wrap_en=0, dir_right=0), dout equals din.
- R2: In wrap mode, dout bit k equals din bit ((k - shift_code) mod 32) for every k, i.e. a left rotate by the code.
- R3: In wrap mode the dir_right and sign_fill inputs have no effect on dout.
- R4: In fill mode with dir_right=0, dout equals din shifted left by shift_code, and the low shift_code bits of dout are 0 whatever sign_fill is.
- R5: In fill mode with dir_right=1, dout equals din shifted right by (32 - shift_code), and the top (32 - shift_code) bits of dout equal sign_fill.
- R6: In fill mode with dir_right=1, shift code 5'b11111 yields a right shift of exactly one place: dout = {sign_fill, din[31:1]}.
- R7: In fill mode with dir_right=1, shift code 5'b00000 yields a right shift of 32: every bit of dout equals sign_fill.
- R8: The direction bit alters only fill value and range, never the code-to-position mapping: for any code c and fill mode, dout bit k is taken from din bit (k - c) when 0 <= k - c < 32 in the left case, and from din bit (k - c + 32) when that lies in 0..31 in the right case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Data word to be shifted |
| shift_code | input | 5 | Left-shift code; low five bits of the signed amount in fill mode |
| wrap_en | input | 1 | 1 = rotate (wrap mode), 0 = fill mode |
| dir_right | input | 1 | Fill mode only: 0 = left with zero fill, 1 = right with sign fill |
| sign_fill | input | 1 | Value entering the vacated high bits on a right fill shift |
| dout | output | 32 | Shifted result |

## Verification
Every code is swept in all three conventions (wrap, fill-left, fill-right) on a single set bit, on alternating bits and on a dense word with both ends set; the single bit shows exactly where each position lands, while the alternating and dense words expose swapped or off-by-one stage distances and wrong fill edges. Random words with random codes, modes and sign-fill values are then compared against a model that reads a window out of the 96-bit sign/data/zero word, so rotation and fill are checked by a different formula than the one the design uses. Directed cases target code 0 and code 31 in the right direction, where a wrong two's-complement reading shows up as a shift of 0 or 31 instead of 32 or 1, and wrap mode is repeated with the direction and sign-fill inputs toggled to show they change nothing.

// File: rtl/shift_wrap_fill_pkg.sv
package shift_wrap_fill_pkg;

  localparam int unsigned DEF_DATA_W = 32;

  // Which doubled source word feeds the left-shift network
  typedef enum logic [1:0] {
    SRC_ROTATE = 2'd0,   // {data, data}
    SRC_ZERO   = 2'd1,   // {data, zeros}
    SRC_SIGN   = 2'd2    // {sign copies, data}
  } src_kind_e;

  function automatic src_kind_e pick_source(input logic wrap, input logic right);
    if (wrap)       return SRC_ROTATE;
    else if (right) return SRC_SIGN;
    else            return SRC_ZERO;
  endfunction

  // Distance moved by network stage idx
  function automatic int unsigned stage_dist(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/shf_source_mux.sv
module shf_source_mux
  import shift_wrap_fill_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned PAIR_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] data_in,
  input  src_kind_e         kind,
  input  logic              sign_in,
  output logic [PAIR_W-1:0] pair_out
);

  always_comb begin
    unique case (kind)
      SRC_ROTATE: pair_out = {data_in, data_in};
      SRC_SIGN:   pair_out = {{DATA_W{sign_in}}, data_in};
      default:    pair_out = {data_in, {DATA_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/shf_log_stage.sv
module shf_log_stage #(
  parameter int unsigned PAIR_W = 64,
  parameter int unsigned DIST   = 1
) (
  input  logic [PAIR_W-1:0] stage_in,
  input  logic              move,
  output logic [PAIR_W-1:0] stage_out
);

  always_comb begin
    if (move) stage_out = {stage_in[PAIR_W-DIST-1:0], {DIST{1'b0}}};
    else      stage_out = stage_in;
  end

endmodule

// File: rtl/shift_wrap_fill.sv
module shift_wrap_fill
  import shift_wrap_fill_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned CODE_W = $clog2(DATA_W),
  localparam int unsigned PAIR_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CODE_W-1:0] shift_code,
  input  logic              wrap_en,
  input  logic              dir_right,
  input  logic              sign_fill,
  output logic [DATA_W-1:0] dout
);

  // Named internal events, visible to the bound checker
  src_kind_e         src_kind;
  logic [PAIR_W-1:0] src_pair;
  logic [PAIR_W-1:0] net [CODE_W+1];
  logic [PAIR_W-1:0] net_final;

  assign src_kind = pick_source(wrap_en, dir_right);

  shf_source_mux #(.DATA_W(DATA_W)) u_src (
    .data_in  (din),
    .kind     (src_kind),
    .sign_in  (sign_fill),
    .pair_out (src_pair)
  );

  assign net[0] = src_pair;

  for (genvar gi = 0; gi < CODE_W; gi++) begin : g_stage
    shf_log_stage #(
      .PAIR_W (PAIR_W),
      .DIST   (stage_dist(gi))
    ) u_stage (
      .stage_in  (net[gi]),
      .move      (shift_code[gi]),
      .stage_out (net[gi+1])
    );
  end

  assign net_final = net[CODE_W];
  // Upper half of the shifted pair is the selected window
  assign dout = net_final[PAIR_W-1:DATA_W];

endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CODE_W = $clog2(DATA_W),
  localparam int unsigned PAIR_W = 2 * DATA_W
) (
  input logic [DATA_W-1:0] din,
  input logic [CODE_W-1:0] shift_code,
  input logic              wrap_en,
  input logic              dir_right,
  input logic              sign_fill,
  input logic [DATA_W-1:0] dout,
  input logic [PAIR_W-1:0] src_pair,
  input logic [PAIR_W-1:0] net_final
);

  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] high_mask;

  always_comb begin
    low_mask  = (DATA_W'(1) << shift_code) - DATA_W'(1);
    // Bits at or above shift_code belong to the sign-filled region on a right shift
    high_mask = ~low_mask;
  end

  always_comb begin
    if (wrap_en) begin
      p_rot_keeps_ones_r2: assert ($countones(dout) == $countones(din));
      p_rot_bit0_lands_r2: assert (dout[shift_code] == din[0]);
      p_rot_halves_match_r3: assert (src_pair[PAIR_W-1:DATA_W] == src_pair[DATA_W-1:0]);
    end
    if (!wrap_en && !dir_right) begin
      p_left_low_zero_r4: assert ((dout & low_mask) == '0);
      p_left_tail_clear_r4: assert (net_final[DATA_W-1:0] == '0);
    end
    if (!wrap_en && dir_right) begin
      p_right_top_sign_r5: assert ((dout & high_mask) == (high_mask & {DATA_W{sign_fill}}));
    end
    if (!wrap_en && dir_right && shift_code == '0) begin
      p_right_full_r7: assert (dout == {DATA_W{sign_fill}});
    end
    if ((wrap_en || !dir_right) && shift_code == '0) begin
      p_zero_code_pass_r1: assert (dout == din);
    end
  end

endmodule

bind shift_wrap_fill shf_checker #(.DATA_W(DATA_W)) u_shf_checker (
  .din        (din),
  .shift_code (shift_code),
  .wrap_en    (wrap_en),
  .dir_right  (dir_right),
  .sign_fill  (sign_fill),
  .dout       (dout),
  .src_pair   (src_pair),
  .net_final  (net_final)
);

// File: tb/test_shift_wrap_fill.sv
module test_shift_wrap_fill;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] din = '0;
  logic [4:0]   shift_code = '0;
  logic         wrap_en = 1'b0;
  logic         dir_right = 1'b0;
  logic         sign_fill = 1'b0;
  logic [W-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  shift_wrap_fill i_shift_wrap_fill (
    .din        (din),
    .shift_code (shift_code),
    .wrap_en    (wrap_en),
    .dir_right  (dir_right),
    .sign_fill  (sign_fill),
    .dout       (dout)
  );

  // Reference: window out of {32 sign, data, 32 zero}, or a modular rotate
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [4:0] c,
                                         input logic wr, input logic rt, input logic s);
    logic [3*W-1:0] ext;
    logic [W-1:0]   r;
    int amt;
    ext = {{W{s}}, d, {W{1'b0}}};
    amt = rt ? int'(c) - W : int'(c);
    for (int k = 0; k < W; k++) begin
      if (wr) r[k] = d[(k - int'(c) + W) % W];
      else    r[k] = ext[W + k - amt];
    end
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] d, input logic [4:0] c,
                       input logic wr, input logic rt, input logic s);
    @(posedge clk);
    din = d; shift_code = c; wrap_en = wr; dir_right = rt; sign_fill = s;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s code=%0d wrap=%0b right=%0b sign=%0b din=%h actual=%h expected=%h",
               tag, shift_code, wrap_en, dir_right, sign_fill, din, dout, exp);
    end
  endtask

  task automatic run_model(input string tag, input logic [W-1:0] d, input logic [4:0] c,
                           input logic wr, input logic rt, input logic s);
    apply(d, c, wr, rt, s);
    check(tag, model(d, c, wr, rt, s));
  endtask

  initial begin
    logic [W-1:0] pats [3];
    logic [W-1:0] base;
    pats[0] = 32'h0000_0001;
    pats[1] = 32'hAAAA_5555;
    pats[2] = 32'h8F3C_21D1;

    // Idle state: all inputs zero gives zero
    @(negedge clk);
    check("R1 idle", '0);

    // R1: code zero passes data in wrap and fill-left
    apply(32'hDEAD_BEEF, 5'd0, 1'b1, 1'b0, 1'b1); check("R1 wrap", 32'hDEAD_BEEF);
    apply(32'hDEAD_BEEF, 5'd0, 1'b0, 1'b0, 1'b1); check("R1 fill-left", 32'hDEAD_BEEF);

    // R6 / R7 directed right-fill corners
    apply(32'h8000_0001, 5'd31, 1'b0, 1'b1, 1'b0); check("R6 right1 s0", 32'h4000_0000);
    apply(32'h8000_0001, 5'd31, 1'b0, 1'b1, 1'b1); check("R6 right1 s1", 32'hC000_0000);
    apply(32'h1234_5678, 5'd0, 1'b0, 1'b1, 1'b1);  check("R7 right32 s1", 32'hFFFF_FFFF);
    apply(32'hFFFF_FFFF, 5'd0, 1'b0, 1'b1, 1'b0);  check("R7 right32 s0", 32'h0000_0000);

    // R4 directed: max left, sign ignored
    apply(32'hFFFF_FFFF, 5'd31, 1'b0, 1'b0, 1'b1); check("R4 left31", 32'h8000_0000);
    apply(32'h0000_FFFF, 5'd16, 1'b0, 1'b0, 1'b1); check("R4 left16", 32'hFFFF_0000);

    // R2 directed rotate
    apply(32'h8000_0001, 5'd1, 1'b1, 1'b0, 1'b0);  check("R2 rotl1", 32'h0000_0003);
    apply(32'h1234_5678, 5'd16, 1'b1, 1'b0, 1'b0); check("R2 rotl16", 32'h5678_1234);

    // R3: wrap result unchanged under every direction / sign combination
    for (int c = 0; c < 32; c += 5) begin
      for (int v = 0; v < 4; v++) begin
        apply(32'hC001_7A35, 5'(c), 1'b1, v[0], v[1]);
        check("R3 wrap ignores dir/sign", {32'hC001_7A35, 32'hC001_7A35} >> (32 - c));
      end
    end

    // Full sweep: every code, each convention, several patterns (R2 R4 R5 R8)
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 32; c++) begin
        run_model("R2 sweep wrap", pats[p], 5'(c), 1'b1, 1'b0, 1'b0);
        run_model("R4 sweep left", pats[p], 5'(c), 1'b0, 1'b0, p[0]);
        run_model("R5 sweep right", pats[p], 5'(c), 1'b0, 1'b1, ~p[0]);
        run_model("R8 sweep right", pats[p], 5'(c), 1'b0, 1'b1, p[0]);
      end
    end

    // Constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      base = $urandom();
      run_model("R8 random", base, 5'($urandom()), 1'($urandom()), 1'($urandom()),
                1'($urandom()));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule